// File: doc/BRIEF.md
# Debug Processor-Access Service Engine

This block sits on the probe side of a debug connection and stands in for memory while a target CPU runs in debug mode. It runs a repeated service round over an abstract scan port: it selects an instruction or scans a 32-bit data register, and collects the value captured from the target. In each round the engine raises a pending-access request in the target's control register and reads the address that the CPU wants. It then either hands back an instruction word or takes a word that the CPU writes. Last, it clears the request so the CPU can go on.

Instruction words come from an internal table of parameterised depth that is loaded before a run. The table is mapped onto a fixed fetch window based at 0xFF200200. `prog_len_i` gives the number of valid words. A write to the fixed mailbox address 0xFF200000 stores the program's result. The run ends cleanly the second time the CPU fetches the window base. It ends with an error if the target reports a reset, drops the pending access, writes to an unexpected address, or runs past the round limit.

Top module: `dpa_service_engine`

## Requirements
- R11: After reset, `busy_o`, `init_o`, `done_o`, `err_o`, `align_warn_o` and `cmd_valid_o` are 0, and `result_o` and `err_code_o` are 0.
- R1: Each round first selects the control instruction (`cmd_ir_o`=1, code 0). It then scans the control register with the access-request bit (default bit 18) set to 1.
- R2: If the captured control word has the reset-occurred bit (default bit 31) set, the run stops. `err_o` pulses with code 1, `init_o` drops to 0, and no release scan is issued.
- R3: If the captured access-request bit is 0, the run stops. `err_o` pulses with code 2 and `init_o` drops to 0.
- R4: After the control scan, the engine selects the address instruction (code 1) and scans the address. Non-zero bits [1:0] are forced to zero and set `align_warn_o`, which stays set until the next start.
- R5: When the captured direction bit (default bit 19) is 1, the access is a write. The engine selects the data instruction (code 2) and scans the data in. Data written to 0xFF200000 is copied to `result_o`. A write to any other address stops the run with code 3 and leaves `init_o` at 1.
- R6: A read at an aligned address A with 0xFF200200 <= A < 0xFF200200 + 4*len is answered by scanning in table word (A-0xFF200200)/4. Any other read is answered with 0. This holds for the last word of the window, for the first address past it, and for len 0.
- R7: When a read of 0xFF200200 follows an earlier read of that address in the same run, the engine issues no data or release scan. `done_o` pulses for one cycle and `busy_o` drops at the same time. `done_o` and `err_o` are never high together.
- R8: Every round that is served ends with the control instruction selected and a control scan with the access-request bit at 0.
- R9: When MAX_ROUNDS rounds have been served without finishing, `err_o` pulses with code 4 at the end of the last release scan.
- R10: A command is transferred when `cmd_valid_o` and `cmd_ready_i` are both high. While it waits, all command fields stay stable. No new command is offered until `rsp_valid_i` has returned the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when idle |
| prog_len_i | input | $clog2(DEPTH+1) | Number of valid table words, latched at start |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | $clog2(DEPTH) | Table write index |
| tbl_data_i | input | 32 | Table write word |
| cmd_valid_o | output | 1 | Scan command offered |
| cmd_ready_i | input | 1 | Scan port accepts command |
| cmd_ir_o | output | 1 | 1: instruction select, 0: data register scan |
| cmd_code_o | output | 2 | Instruction code: 0 control, 1 address, 2 data |
| cmd_dr_o | output | 32 | Word scanned into the data register |
| rsp_valid_i | input | 1 | Captured value returned |
| rsp_data_i | input | 32 | Captured data register value |
| busy_o | output | 1 | Run in progress |
| init_o | output | 1 | Target link considered initialised |
| done_o | output | 1 | One-cycle pulse on clean finish |
| err_o | output | 1 | One-cycle pulse on abort |
| err_code_o | output | 3 | Last abort reason: 1 reset, 2 no access, 3 unknown write, 4 timeout |
| align_warn_o | output | 1 | Misaligned address seen in this run |
| result_o | output | 32 | Last mailbox word |

## Verification
The checker assumes that the scan port returns exactly one `rsp_valid_i` pulse for each accepted command, and never while no command is outstanding. It also assumes that `start_i` is pulsed only while the engine is idle. The bench's target model keeps to these assumptions: it answers one negative edge after the transfer and only for commands it has accepted. It also drops `cmd_ready_i` in a fixed pattern during one run, which exercises the hold rule. The table is loaded only between runs, so that fetched words stay stable while a round is in progress.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    IR_CTRL = 2'd0,
    IR_ADDR = 2'd1,
    IR_DATA = 2'd2
  } ir_code_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_RESET   = 3'd1,
    ERR_NOACC   = 3'd2,
    ERR_UNK_WR  = 3'd3,
    ERR_TIMEOUT = 3'd4
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTL_IR, ST_CTL_DR, ST_ADR_IR, ST_ADR_DR,
    ST_DAT_IR, ST_DAT_DR, ST_REL_IR, ST_REL_DR
  } st_e;
endpackage

// File: rtl/dpa_prog_table.sv
module dpa_prog_table #(
  parameter int unsigned DEPTH = 16,
  parameter logic [31:0] BASE  = 32'hFF20_0200,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [31:0]      wdata_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      raddr_i,
  output logic [31:0]      rdata_o
);
  logic [31:0]      mem_q [DEPTH];
  logic [31:0]      word_idx;
  logic [LEN_W-1:0] eff_len;
  logic             hit;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // window length never exceeds table depth
  assign eff_len  = (len_i > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_i;
  assign word_idx = (raddr_i - BASE) >> 2;
  assign hit      = (raddr_i >= BASE) && (word_idx < 32'(eff_len));
  assign rdata_o  = hit ? mem_q[word_idx[IDX_W-1:0]] : '0;
endmodule

// File: rtl/dpa_round_wdog.sv
module dpa_round_wdog #(
  parameter int unsigned MAX_ROUNDS = 1024,
  localparam int unsigned CW = $clog2(MAX_ROUNDS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == CW'(MAX_ROUNDS - 1));
endmodule

// File: rtl/dpa_service_engine.sv
module dpa_service_engine
  import dpa_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned MAX_ROUNDS = 1024,
  parameter int unsigned PRACC_BIT  = 18,
  parameter int unsigned ROCC_BIT   = 31,
  parameter int unsigned RNW_BIT    = 19,
  parameter logic [31:0] FETCH_BASE = 32'hFF20_0200,
  parameter logic [31:0] MAILBOX    = 32'hFF20_0000,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  prog_len_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [WORD_W-1:0] tbl_data_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_ir_o,
  output logic [1:0]        cmd_code_o,
  output logic [WORD_W-1:0] cmd_dr_o,
  input  logic              rsp_valid_i,
  input  logic [WORD_W-1:0] rsp_data_i,
  output logic              busy_o,
  output logic              init_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_code_o,
  output logic              align_warn_o,
  output logic [WORD_W-1:0] result_o
);
  st_e               st_q;
  logic              wait_q, rnw_q, seen_base_q, init_q, warn_q, done_q, err_q;
  logic [2:0]        err_code_q;
  logic [LEN_W-1:0]  len_q;
  logic [WORD_W-1:0] addr_q, result_q, fetch_word, aligned;
  logic              accept, fire, launch, wd_tick, wd_expire;

  assign accept  = cmd_valid_o && cmd_ready_i;
  assign fire    = wait_q && rsp_valid_i;
  assign launch  = (st_q == ST_IDLE) && start_i;
  assign wd_tick = fire && (st_q == ST_REL_DR);
  assign aligned = {rsp_data_i[WORD_W-1:2], 2'b00};

  dpa_prog_table #(.DEPTH(DEPTH), .BASE(FETCH_BASE)) u_table (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .len_i   (len_q),
    .raddr_i (addr_q),
    .rdata_o (fetch_word)
  );

  dpa_round_wdog #(.MAX_ROUNDS(MAX_ROUNDS)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (launch),
    .tick_i   (wd_tick),
    .expire_o (wd_expire)
  );

  always_comb begin
    cmd_valid_o = (st_q != ST_IDLE) && !wait_q;
    cmd_ir_o    = 1'b0;
    cmd_code_o  = IR_CTRL;
    cmd_dr_o    = '0;
    case (st_q)
      ST_CTL_IR, ST_REL_IR: cmd_ir_o = 1'b1;
      ST_CTL_DR: cmd_dr_o = WORD_W'(1) << PRACC_BIT;
      ST_ADR_IR: begin cmd_ir_o = 1'b1; cmd_code_o = IR_ADDR; end
      ST_DAT_IR: begin cmd_ir_o = 1'b1; cmd_code_o = IR_DATA; end
      ST_DAT_DR: cmd_dr_o = rnw_q ? '0 : fetch_word;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      wait_q      <= 1'b0;
      rnw_q       <= 1'b0;
      seen_base_q <= 1'b0;
      init_q      <= 1'b0;
      warn_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      err_code_q  <= ERR_NONE;
      len_q       <= '0;
      addr_q      <= '0;
      result_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) wait_q <= 1'b1;
      if (fire)   wait_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q        <= ST_CTL_IR;
          init_q      <= 1'b1;
          warn_q      <= 1'b0;
          seen_base_q <= 1'b0;
          err_code_q  <= ERR_NONE;
          result_q    <= '0;
          len_q       <= prog_len_i;
        end
        ST_CTL_IR: if (fire) st_q <= ST_CTL_DR;
        ST_CTL_DR: if (fire) begin
          if (rsp_data_i[ROCC_BIT]) begin
            st_q <= ST_IDLE; err_q <= 1'b1; err_code_q <= ERR_RESET; init_q <= 1'b0;
          end else if (!rsp_data_i[PRACC_BIT]) begin
            st_q <= ST_IDLE; err_q <= 1'b1; err_code_q <= ERR_NOACC; init_q <= 1'b0;
          end else begin
            rnw_q <= rsp_data_i[RNW_BIT];
            st_q  <= ST_ADR_IR;
          end
        end
        ST_ADR_IR: if (fire) st_q <= ST_ADR_DR;
        ST_ADR_DR: if (fire) begin
          addr_q <= aligned;
          if (rsp_data_i[1:0] != 2'b00) warn_q <= 1'b1;
          if (!rnw_q && (aligned == FETCH_BASE) && seen_base_q) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            if (!rnw_q && (aligned == FETCH_BASE)) seen_base_q <= 1'b1;
            st_q <= ST_DAT_IR;
          end
        end
        ST_DAT_IR: if (fire) st_q <= ST_DAT_DR;
        ST_DAT_DR: if (fire) begin
          if (rnw_q && (addr_q != MAILBOX)) begin
            st_q <= ST_IDLE; err_q <= 1'b1; err_code_q <= ERR_UNK_WR;
          end else begin
            if (rnw_q) result_q <= rsp_data_i;
            st_q <= ST_REL_IR;
          end
        end
        ST_REL_IR: if (fire) st_q <= ST_REL_DR;
        ST_REL_DR: if (fire) begin
          if (wd_expire) begin
            st_q <= ST_IDLE; err_q <= 1'b1; err_code_q <= ERR_TIMEOUT;
          end else begin
            st_q <= ST_CTL_IR;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign init_o       = init_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign err_code_o   = err_code_q;
  assign align_warn_o = warn_q;
  assign result_o     = result_q;
endmodule

// File: rtl/dpa_service_engine_chk.sv
module dpa_service_engine_chk
  import dpa_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic        cmd_ir_o,
  input logic [1:0]  cmd_code_o,
  input logic [31:0] cmd_dr_o,
  input logic        busy_o,
  input logic        init_o,
  input logic        done_o,
  input logic        err_o,
  input logic [2:0]  err_code_o
);
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_ir_o)
      && $stable(cmd_code_o) && $stable(cmd_dr_o)); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o); // R11

  AST_END_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o && !(done_o && err_o)); // R7

  AST_LINK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && (err_code_o == 3'(ERR_RESET) || err_code_o == 3'(ERR_NOACC)) |-> !init_o); // R2

  AST_LINK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && (err_code_o == 3'(ERR_UNK_WR)) |-> init_o); // R5
endmodule

bind dpa_service_engine dpa_service_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_ir_o    (cmd_ir_o),
  .cmd_code_o  (cmd_code_o),
  .cmd_dr_o    (cmd_dr_o),
  .busy_o      (busy_o),
  .init_o      (init_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .err_code_o  (err_code_o)
);

// File: tb/dpa_service_engine_tb.sv
`timescale 1ns/1ps
module dpa_service_engine_tb;
  localparam int DEPTH = 16;
  localparam int MAXR  = 12;
  localparam logic [31:0] BASE = 32'hFF20_0200;
  localparam logic [31:0] MBOX = 32'hFF20_0000;

  typedef struct packed {
    logic        rocc;
    logic        pracc;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
  } acc_t;

  logic clk = 0, rst_n = 0;
  logic start = 0, tbl_we = 0, cmd_ready = 1, rsp_valid = 0;
  logic [4:0]  prog_len = 0;
  logic [3:0]  tbl_addr = 0;
  logic [31:0] tbl_data = 0, rsp_data = 0;
  logic cmd_valid, cmd_ir, busy, init, done, err, warn;
  logic [1:0]  cmd_code;
  logic [31:0] cmd_dr, result;
  logic [2:0]  err_code;

  always #4 clk = ~clk;

  dpa_service_engine #(.DEPTH(DEPTH), .MAX_ROUNDS(MAXR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .prog_len_i(prog_len),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_ir_o(cmd_ir),
    .cmd_code_o(cmd_code), .cmd_dr_o(cmd_dr), .rsp_valid_i(rsp_valid),
    .rsp_data_i(rsp_data), .busy_o(busy), .init_o(init), .done_o(done),
    .err_o(err), .err_code_o(err_code), .align_warn_o(warn), .result_o(result)
  );

  int total = 0, fails = 0;
  acc_t script[$];
  logic [31:0] exp_q[$];
  int idx, req_cnt, rel_cnt, cyc = 0, stall_ctr = 0;
  bit stall_en = 0, pend = 0, got_done, got_err;
  logic [1:0]  cur_ir = 0;
  logic [31:0] pend_data;
  logic [2:0]  got_code;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tword(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h1001;
  endfunction

  // target model and scoreboard monitor
  task automatic serve(output logic [31:0] d);
    acc_t a;
    d = '0;
    a = (idx < script.size()) ? script[idx] : '0;
    if (cmd_ir) cur_ir = cmd_code;
    else case (cur_ir)
      2'd0: if (cmd_dr[18]) begin
        req_cnt++;
        d = (32'(a.rocc) << 31) | (32'(a.pracc) << 18) | (32'(a.wr) << 19);
      end else begin
        rel_cnt++;
        idx++;
      end
      2'd1: d = a.addr;
      2'd2: if (a.wr) d = a.wdata;
            else if (exp_q.size() == 0) chk("R6 unexpected fetch", cmd_dr, 32'hx);
            else chk("R6 fetched word", cmd_dr, exp_q.pop_front());
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    rsp_valid = 0;
    if (stall_en) begin stall_ctr++; cmd_ready = (stall_ctr % 3) != 0; end
    else cmd_ready = 1;
    if (pend) begin
      rsp_valid = 1; rsp_data = pend_data; pend = 0;
    end else if (cmd_valid && cmd_ready) begin
      serve(pend_data); pend = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic add_rd(input logic [31:0] a, input bit expect_it, input logic [31:0] w);
    script.push_back('{rocc:1'b0, pracc:1'b1, wr:1'b0, addr:a, wdata:32'h0});
    if (expect_it) exp_q.push_back(w);  // driver pushes expected fetch
  endtask

  task automatic add_wr(input logic [31:0] a, input logic [31:0] w);
    script.push_back('{rocc:1'b0, pracc:1'b1, wr:1'b1, addr:a, wdata:w});
  endtask

  task automatic run(input int len);
    idx = 0; req_cnt = 0; rel_cnt = 0;
    @(negedge clk); prog_len = 5'(len); start = 1;
    @(negedge clk); start = 0;
    while (!(done || err)) @(negedge clk);
    got_done = done; got_err = err; got_code = err_code;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", 32'(busy), 0);
    chk("R11 init", 32'(init), 0);
    chk("R11 done/err", {30'b0, done, err}, 0);
    chk("R11 warn", 32'(warn), 0);
    chk("R11 result", result, 0);
    chk("R11 cmd_valid", 32'(cmd_valid), 0);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); tbl_we = 1; tbl_addr = 4'(i); tbl_data = tword(i);
    end
    @(negedge clk); tbl_we = 0;

    // main program with stalled scan port
    stall_en = 1;
    script.delete();
    add_rd(BASE,          1, tword(0));
    add_rd(BASE + 4,      1, tword(1));
    add_rd(BASE + 32'hA,  1, tword(2));   // misaligned
    add_rd(BASE + 32'h40, 1, 0);          // outside window
    add_wr(MBOX, 32'h1234_ABCD);
    add_rd(BASE + 32'hC,  1, tword(3));   // last word
    add_rd(BASE + 32'h10, 1, 0);          // first past window
    add_rd(BASE - 4,      1, 0);          // below window
    add_rd(BASE,          0, 0);          // second base fetch
    run(4);
    stall_en = 0;
    chk("R7 done pulse", {31'b0, got_done}, 1);
    chk("R7 no error", {31'b0, got_err}, 0);
    chk("R5 mailbox result", result, 32'h1234_ABCD);
    chk("R4 align warning", 32'(warn), 1);
    chk("R1 control requests", 32'(req_cnt), 9);
    chk("R8 releases", 32'(rel_cnt), 8);
    chk("R7 all fetches served", 32'(exp_q.size()), 0);
    chk("R7 idle after done", 32'(busy), 0);

    // reset-occurred abort
    script.delete();
    script.push_back('{rocc:1'b1, pracc:1'b1, wr:1'b0, addr:BASE, wdata:32'h0});
    run(4);
    chk("R2 error pulse", {31'b0, got_err}, 1);
    chk("R2 error code", 32'(got_code), 1);
    chk("R2 init cleared", 32'(init), 0);
    chk("R2 no release", 32'(rel_cnt), 0);
    chk("R4 warn cleared by start", 32'(warn), 0);

    // no pending access
    script.delete();
    script.push_back('{rocc:1'b0, pracc:1'b0, wr:1'b0, addr:BASE, wdata:32'h0});
    run(4);
    chk("R3 error code", 32'(got_code), 2);
    chk("R3 init cleared", 32'(init), 0);

    // unknown write
    script.delete();
    add_wr(BASE + 4, 32'hDEAD_BEEF);
    run(4);
    chk("R5 unknown write code", 32'(got_code), 3);
    chk("R5 init kept", 32'(init), 1);
    chk("R5 result untouched", result, 0);

    // round limit
    script.delete();
    for (int i = 0; i < MAXR + 1; i++) add_rd(BASE + 4, (i < MAXR), tword(1));
    run(2);
    chk("R9 timeout code", 32'(got_code), 4);
    chk("R9 rounds served", 32'(rel_cnt), MAXR);
    chk("R9 fetches", 32'(exp_q.size()), 0);

    // empty window
    script.delete();
    exp_q.delete();
    add_rd(BASE, 1, 0);
    add_rd(BASE, 0, 0);
    run(0);
    chk("R6 len0 done", {31'b0, got_done}, 1);
    chk("R6 len0 fetches", 32'(exp_q.size()), 0);
    chk("R8 len0 releases", 32'(rel_cnt), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule